// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block applies one gamma transfer curve to a stream of pixels. Each beat holds three 12-bit colour components, and all three use the same curve. The code range 0 to 4095 is split into 64 linear segments. The segments are narrow near black and widen toward white. For each component the block finds the segment that holds the code, then computes a base level plus a scaled slope term. The result is clipped at full scale.

A host loads the curve one segment at a time through a write strobe, an address and a packed coefficient word. These writes go into a staging copy. A frame-start pulse moves the whole staged curve into the working copy in a single cycle, so pixels of one frame never see a half-updated curve. A per-beat bypass flag passes a beat through unchanged, with the same latency as a graded beat. Pixels enter and leave on valid/ready streams, and the pipeline is two registers deep.

Top module: `gamma_pwl_eval`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1. Every working coefficient is zero, so a graded beat accepted before the first frame-start comes out as all zeros.
- R2: Segment layout.
  - Codes 0 to 15 each form their own segment, numbered 0 to 15.
  - Codes 16 to 511 fill segments 16 to 35. These are five groups of four equal segments, with widths of 4, 8, 16, 32 and 64 codes in turn.
  - Codes 512 to 4095 fill segments 36 to 63, each 128 codes wide.
- R3: A coefficient write stores the word into the staging entry whose index is `cfgAddr`. The slope is taken from `cfgData[27:16]` and the base level from `cfgData[11:0]`.
- R4: A graded component with code x in segment s, starting at code L, gives min(4095, base[s] + ((slope[s] × (x − L)) >> 8)).
- R5: Component lane k sits in bits [12k+11:12k] of `inData` and `outData`. Lane 0 is red, lane 1 is green and lane 2 is blue. All lanes use the same curve.
- R6: Coefficient writes do not affect any pixel until a `frameStart` pulse, which copies all staged entries into the working set at once. A beat accepted at the same clock edge as the pulse, or earlier, uses the old set. A beat accepted after the pulse uses the new set.
- R7: A beat accepted with `bypass` at 1 leaves with `outData` equal to its `inData`. Its latency matches a graded beat. The flag is captured per beat.
- R8: With the output not stalled, a beat accepted at a rising edge shows `outValid` at 0 after that edge and at 1 after the next edge.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds. Once both pipeline stages are full, `inReady` is 0. Beats leave in the order they were accepted.
- R10: Bits 31:28 and 15:12 of `cfgData` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Coefficient write strobe |
| cfgAddr | input | 6 | Segment index of the write |
| cfgData | input | 32 | Packed coefficient word: slope in 27:16, base level in 11:0 |
| frameStart | input | 1 | Copies the staged curve into the working curve |
| bypass | input | 1 | Pass the beat through unchanged |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high together with inValid |
| inData | input | 36 | Three 12-bit input components |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream accepts the output beat |
| outData | output | 36 | Three 12-bit output components |

## Verification
The hardest case to reach from the ports is a curve swap that lands exactly on the edge where a beat is accepted. The bench pairs a `frameStart` pulse with a beat on the same edge and sends a second beat one cycle later. The first beat must use the old base level and the second the new one. Segment edges and saturation are covered by sweeping every input code through all three lanes against a curve chosen so that neighbouring segments differ and the top segment clips. A full two-beat stall with output back-pressure checks hold, ordering and `inReady`.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  localparam int PIX_W      = 12;
  localparam int LANES      = 3;
  localparam int SEG_CNT    = 64;
  localparam int SEG_IW     = $clog2(SEG_CNT);
  localparam int CFG_W      = 32;
  localparam int SLOPE_W    = 12;
  localparam int OFFS_W     = 12;
  localparam int SLOPE_LSB  = 16;
  localparam int FRAC_W     = 8;
  localparam int FINE_CNT   = 16;
  localparam int FINE_BITS  = $clog2(FINE_CNT);
  localparam int SECT_CNT   = 5;
  localparam int SECT_SEGS  = 4;
  localparam int SECT_BITS  = $clog2(SECT_SEGS);
  localparam int COARSE_SH  = 7;
  localparam int DX_W       = COARSE_SH;
  localparam int PROD_W     = SLOPE_W + DX_W;
  localparam int BUS_W      = LANES * PIX_W;
  localparam int COARSE_CNT = 1 << (PIX_W - COARSE_SH);

  typedef struct packed {
    logic [SLOPE_W-1:0] slope;
    logic [OFFS_W-1:0]  offs;
  } coef_t;

  typedef struct packed {
    logic load1;
    logic load2;
    logic commit;
  } pipeCtl_t;

  typedef struct packed {
    logic [SEG_IW-1:0] idx;
    logic [PIX_W-1:0]  start;
  } segHit_t;

  // Segment index and start code from the leading-one position.
  function automatic segHit_t findSeg(logic [PIX_W-1:0] x);
    segHit_t hit;
    int msb;
    int sh;
    int segNo;
    msb = 0;
    for (int b = 0; b < PIX_W; b++)
      if (x[b]) msb = b;
    if (int'(x) < FINE_CNT) begin
      hit.idx   = SEG_IW'(x);
      hit.start = x;
    end else if (msb < FINE_BITS + SECT_CNT) begin
      sh        = msb - SECT_BITS;
      segNo     = FINE_CNT + SECT_SEGS * (msb - FINE_BITS)
                + int'((x >> sh) & PIX_W'(SECT_SEGS - 1));
      hit.idx   = SEG_IW'(segNo);
      hit.start = (x >> sh) << sh;
    end else begin
      segNo     = SEG_CNT - COARSE_CNT + int'(x >> COARSE_SH);
      hit.idx   = SEG_IW'(segNo);
      hit.start = (x >> COARSE_SH) << COARSE_SH;
    end
    return hit;
  endfunction
endpackage

// File: rtl/gamma_pwl_coef_bank.sv
module gamma_pwl_coef_bank
  import gamma_pwl_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [SEG_IW-1:0]          cfgAddr,
  input  logic [CFG_W-1:0]           cfgData,
  input  logic                       commit,
  output coef_t [SEG_CNT-1:0]        activeTab
);
  coef_t [SEG_CNT-1:0] shadowTab;
  coef_t               wrWord;

  assign wrWord.slope = cfgData[SLOPE_LSB +: SLOPE_W];
  assign wrWord.offs  = cfgData[OFFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowTab <= '0;
      activeTab <= '0;
    end else begin
      if (cfgWe) shadowTab[cfgAddr] <= wrWord;
      if (commit) activeTab <= shadowTab;
    end
  end

  AST_COMMIT_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> $stable(activeTab)); // R6

  AST_FIELD_PICK: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> shadowTab[$past(cfgAddr)] ==
      {$past(cfgData[SLOPE_LSB +: SLOPE_W]), $past(cfgData[OFFS_W-1:0])}); // R3
endmodule

// File: rtl/gamma_pwl_ctrl.sv
module gamma_pwl_ctrl
  import gamma_pwl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     frameStart,
  output logic     inReady,
  output logic     outValid,
  output pipeCtl_t ctl
);
  logic stage1Full;
  logic stage2Full;
  logic advance;

  assign advance    = !stage2Full || outReady;
  assign inReady    = advance;
  assign outValid   = stage2Full;
  assign ctl.load1  = advance;
  assign ctl.load2  = advance;
  assign ctl.commit = frameStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
      stage2Full <= 1'b0;
    end else if (advance) begin
      stage1Full <= inValid;
      stage2Full <= stage1Full;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R9
endmodule

// File: rtl/gamma_pwl_dp.sv
module gamma_pwl_dp
  import gamma_pwl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pipeCtl_t             ctl,
  input  logic [BUS_W-1:0]     inData,
  input  logic                 bypass,
  input  coef_t [SEG_CNT-1:0]  activeTab,
  output logic [BUS_W-1:0]     outData
);
  logic byp1;

  always_ff @(posedge clk) begin
    if (!rstN) byp1 <= 1'b0;
    else if (ctl.load1) byp1 <= bypass;
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [PIX_W-1:0]  pixIn;
    segHit_t           hit;
    coef_t             coef1;
    logic [DX_W-1:0]   dx1;
    logic [PIX_W-1:0]  pix1;
    logic [PROD_W-1:0] prod;
    logic [PIX_W:0]    sum;
    logic [PIX_W-1:0]  graded;

    assign pixIn = inData[ln*PIX_W +: PIX_W];
    assign hit   = findSeg(pixIn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        coef1 <= '0;
        dx1   <= '0;
        pix1  <= '0;
      end else if (ctl.load1) begin
        coef1 <= activeTab[hit.idx];
        dx1   <= DX_W'(pixIn - hit.start);
        pix1  <= pixIn;
      end
    end

    assign prod   = PROD_W'(coef1.slope) * PROD_W'(dx1);
    assign sum    = {1'b0, coef1.offs} + (PIX_W+1)'(prod >> FRAC_W);
    assign graded = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) outData[ln*PIX_W +: PIX_W] <= '0;
      else if (ctl.load2) outData[ln*PIX_W +: PIX_W] <= byp1 ? pix1 : graded;
    end
  end
endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
  import gamma_pwl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEG_IW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              frameStart,
  input  logic              bypass,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BUS_W-1:0]  inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [BUS_W-1:0]  outData
);
  pipeCtl_t            ctl;
  coef_t [SEG_CNT-1:0] activeTab;

  gamma_pwl_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .frameStart(frameStart), .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  gamma_pwl_coef_bank i_bank (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .commit(ctl.commit), .activeTab(activeTab)
  );

  gamma_pwl_dp i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .bypass(bypass),
    .activeTab(activeTab), .outData(outData)
  );

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) ##1 inReady |=> outValid); // R8

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && bypass) ##1 inReady |=> outData == $past(inData, 2)); // R7
endmodule

// File: tb/test_gamma_pwl_eval.sv
module test_gamma_pwl_eval;
  localparam int CLK_HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        frameStart = 1'b0;
  logic        bypass = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [35:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [35:0] outData;

  int checks = 0;
  int fails  = 0;
  int segLo[64];
  int curSlope[64], curOffs[64], pendSlope[64], pendOffs[64];
  logic [35:0] expQ[$];
  string       tagQ[$];

  always #CLK_HALF clk = ~clk;

  gamma_pwl_eval i_gamma_pwl_eval (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameStart(frameStart), .bypass(bypass), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [35:0] expBeat(logic [35:0] d, logic byp);
    logic [35:0] r;
    for (int l = 0; l < 3; l++) begin
      int x = int'(d[12*l +: 12]);
      int v;
      int s = 0;
      for (int i = 0; i < 64; i++) if (x >= segLo[i]) s = i;
      if (byp) v = x;
      else begin
        v = curOffs[s] + ((curSlope[s] * (x - segLo[s])) >> 8);
        if (v > 4095) v = 4095;
      end
      r[12*l +: 12] = 12'(v);
    end
    return r;
  endfunction

  // Called just after a falling edge; returns just after a falling edge.
  task automatic sendBeat(input logic [35:0] d, input logic byp, input logic withCommit, input string tag);
    logic acc;
    logic cmt;
    inValid = 1'b1; inData = d; bypass = byp; frameStart = withCommit;
    forever begin
      #1 acc = inReady;
      cmt = frameStart;
      @(posedge clk);
      if (acc) begin
        expQ.push_back(expBeat(d, byp));
        tagQ.push_back(tag);
      end
      if (cmt) begin
        curSlope = pendSlope;
        curOffs  = pendOffs;
      end
      @(negedge clk);
      frameStart = 1'b0;
      if (acc) break;
    end
    inValid = 1'b0;
  endtask

  task automatic writeCoef(input int a, input int slope, input int offs, input logic [7:0] junk);
    cfgWe = 1'b1; cfgAddr = 6'(a);
    cfgData = {junk[7:4], 12'(slope), junk[3:0], 12'(offs)};
    @(negedge clk);
    cfgWe = 1'b0;
    pendSlope[a] = slope & 12'hFFF;
    pendOffs[a]  = offs & 12'hFFF;
  endtask

  // Scoreboard: beats transfer at the next rising edge.
  always @(negedge clk) begin
    #2;
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) check(1'b0, "R9 unexpected beat", outData, '0);
      else begin
        logic [35:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(outData === e, t, outData, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [35:0] held;
    int idx;
    idx = 0;
    for (int i = 0; i < 16; i++) segLo[idx++] = i;
    for (int s = 0; s < 5; s++)
      for (int j = 0; j < 4; j++) segLo[idx++] = 16 * (1 << s) + j * (4 << s);
    for (int j = 0; j < 28; j++) segLo[idx++] = 512 + 128 * j;
    for (int i = 0; i < 64; i++) begin
      curSlope[i] = 0; curOffs[i] = 0; pendSlope[i] = 0; pendOffs[i] = 0;
    end

    repeat (3) @(negedge clk);
    #2;
    check(outValid == 1'b0, "R1 outValid in reset", {35'b0, outValid}, '0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(outValid == 1'b0, "R1 outValid after reset", {35'b0, outValid}, '0);
    check(inReady == 1'b1, "R1 inReady after reset", {35'b0, inReady}, 36'd1);
    #1;
    @(negedge clk);

    // R1: working set is zero.
    sendBeat({12'd4095, 12'd600, 12'd17}, 1'b0, 1'b0, "R1 zero curve");

    // Load a curve; stray bits set (R10). No commit yet: R6.
    for (int s = 0; s < 64; s++) begin
      int sl = (s * 173 + 29) % 4096;
      int of = (s * 64 + (s * 37) % 50) % 4096;
      if (s == 63) begin sl = 4095; of = 4050; end
      writeCoef(s, sl, of, 8'hA5 ^ 8'(s));
    end
    sendBeat({12'd0, 12'd300, 12'd3000}, 1'b0, 1'b0, "R6 before commit");
    sendBeat({12'd5, 12'd20, 12'd4095}, 1'b0, 1'b1, "R6 accept on commit edge");
    sendBeat({12'd5, 12'd20, 12'd4095}, 1'b0, 1'b0, "R6 after commit R10");

    // Sweep all codes through all lanes, with bypass beats mixed in.
    for (int x = 0; x < 4096; x++) begin
      logic [35:0] d;
      logic b;
      d = {12'((x + 2730) % 4096), 12'((x + 1365) % 4096), 12'(x)};
      b = (x % 7 == 3);
      if (b) sendBeat(d, 1'b1, 1'b0, "R7 bypass");
      else sendBeat(d, 1'b0, 1'b0, "R2 R4 R5 R10 sweep");
    end

    // R8 latency from an idle pipeline.
    repeat (3) @(negedge clk);
    sendBeat({12'd1000, 12'd64, 12'd15}, 1'b0, 1'b0, "R8 latency data");
    #1;
    check(outValid == 1'b0, "R8 not valid after one edge", {35'b0, outValid}, '0);
    @(negedge clk);
    #1;
    check(outValid == 1'b1, "R8 valid after two edges", {35'b0, outValid}, 36'd1);
    @(negedge clk);

    // R9: fill both stages under stall.
    outReady = 1'b0;
    sendBeat({12'd511, 12'd512, 12'd16}, 1'b0, 1'b0, "R9 first in order");
    sendBeat({12'd100, 12'd200, 12'd300}, 1'b1, 1'b0, "R9 second in order");
    #1;
    held = outData;
    repeat (3) begin
      @(negedge clk);
      #1;
      check(outValid == 1'b1, "R9 valid held", {35'b0, outValid}, 36'd1);
      check(outData == held, "R9 data held", outData, held);
      check(inReady == 1'b0, "R9 inReady low when full", {35'b0, inReady}, '0);
    end
    @(negedge clk);
    outReady = 1'b1;

    // Second curve swap replaces segment 0 only.
    writeCoef(0, 0, 777, 8'hFF);
    sendBeat({12'd0, 12'd0, 12'd0}, 1'b0, 1'b1, "R6 old set on commit edge");
    sendBeat({12'd0, 12'd0, 12'd0}, 1'b0, 1'b0, "R6 new set after commit");

    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule